// File: doc/BRIEF.md
# Interlocked Byte Handshake Responder (Initiator Side)

This block sits on the initiator side of a parallel peripheral bus that moves one byte plus an odd parity bit per four-edge request/acknowledge interlock. The target owns the request line and the direction line. The block only answers. When the direction line says the target is sending, the block takes the byte off the bus and acknowledges it. When the direction line says the target is receiving, the block puts a byte from the host onto the bus, lets the lines settle for a fixed time and then acknowledges. In both directions the acknowledge is withdrawn only after the target has dropped its request. The same interlock serves every information phase: command, data, status and message.

The raw request and direction inputs pass through two-flop synchronizers. The direction is taken from its synchronized level in the cycle where the synchronized request is first seen high. The host side uses a valid/ready byte port in each direction. The receive side has a one-byte holding register, and the send side takes one byte per transfer. The settle time is a parameter in picoseconds. It is turned into a whole number of clock cycles, rounded up.

Top module: `bus_init_responder`

## Requirements
- R1: After reset, `bus_ack_o`, `rx_valid_o`, `tx_ready_o`, `par_err_o` and `bus_oe_o` are all 0.
- R2: With the direction line at 1 (target sends), a request causes the bus byte to appear on `rx_data_o` with `rx_valid_o` at 1, and `bus_ack_o` rises. This holds for all 256 byte values.
- R3: Once `bus_ack_o` is 1, it stays 1 while the synchronized request is 1. It falls in the third clock edge after the raw request falls. It is therefore still 1 two sampled cycles after the raw drop and 0 after the third.
- R4: With the direction line at 0 (target receives), the accepted host byte is on `bus_d_o` and `bus_p_o` is its odd parity, so the nine bits hold an odd number of ones. Both stay unchanged while `bus_ack_o` is 1.
- R5: In an outgoing transfer, `bus_ack_o` is 0 during exactly SETTLE cycles after the clock edge that accepts the host byte, and is 1 after that. SETTLE is ceil(SETTLE_PS / CLK_PERIOD_PS), with a minimum of 1.
- R6: If no host byte is offered on an outgoing request, the block holds `tx_ready_o` at 1 and `bus_ack_o` at 0 until `tx_valid_i` is 1.
- R7: If `rx_valid_o` is still 1 when a new incoming request arrives, the block does not acknowledge and keeps the held byte. It captures and acknowledges once the host has taken the held byte.
- R8: An incoming byte whose nine bits hold an even number of ones sets `par_err_o`. The flag then stays 1 until reset. Correctly coded bytes never set it.
- R9: `bus_oe_o` is 0 whenever the synchronized direction line is 1. It is 1 when the synchronized direction line is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Request from the target (raw, asynchronous) |
| bus_io_i | input | 1 | Direction from the target: 1 = target sends (raw) |
| bus_d_i | input | DW | Data lines as seen on the bus |
| bus_p_i | input | 1 | Parity line as seen on the bus |
| bus_d_o | output | DW | Data the block drives onto the bus |
| bus_p_o | output | 1 | Odd parity of `bus_d_o` |
| bus_oe_o | output | 1 | Output enable for the data and parity drivers |
| bus_ack_o | output | 1 | Acknowledge to the target |
| rx_valid_o | output | 1 | A received byte is held for the host |
| rx_data_o | output | DW | Received byte |
| rx_ready_i | input | 1 | Host takes the received byte |
| tx_valid_i | input | 1 | Host offers a byte to send |
| tx_data_i | input | DW | Byte to send |
| tx_ready_o | output | 1 | Block takes the offered byte |
| par_err_o | output | 1 | Sticky parity error on received bytes |

## Verification
All 256 byte values are sent through each direction, each with correct parity. This separates data-path faults on single bits from faults in the parity generator and checker. Bytes with bad parity, mixed with good ones, show whether the error flag is set only by a real mismatch and whether it stays set. Two stall patterns are used: a request with no host byte offered, and a request while the host still holds an earlier byte. These show whether the acknowledge waits for the local side. The acknowledge delay is counted cycle by cycle, and the request is held high for extra cycles, to tell a correct settle count and a correct four-edge release from off-by-one or early-release errors.

// File: rtl/bus_init_responder_pkg.sv
package bus_init_responder_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_TXWAIT = 2'd1,
    ST_SETTLE = 2'd2,
    ST_ACK    = 2'd3
  } hs_state_e;

  function automatic logic odd_par(input logic [7:0] b);
    return ~(^b);
  endfunction
endpackage

// File: rtl/bir_sync.sv
module bir_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= RST_VAL[i];
        sync_q[i] <= RST_VAL[i];
      end else begin
        meta_q[i] <= d[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/bir_settle.sv
module bir_settle #(
  parameter int CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);
  localparam int CW = (CYC < 2) ? 1 : $clog2(CYC);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start | (run & ~done);
    cnt_d  = start ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = run & (cnt_q == LAST);

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/bus_init_responder.sv
module bus_init_responder
  import bus_init_responder_pkg::*;
#(
  parameter int DW            = 8,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int SETTLE_PS     = 55000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req_i,
  input  logic          bus_io_i,
  input  logic [DW-1:0] bus_d_i,
  input  logic          bus_p_i,
  output logic [DW-1:0] bus_d_o,
  output logic          bus_p_o,
  output logic          bus_oe_o,
  output logic          bus_ack_o,
  output logic          rx_valid_o,
  output logic [DW-1:0] rx_data_o,
  input  logic          rx_ready_i,
  input  logic          tx_valid_i,
  input  logic [DW-1:0] tx_data_i,
  output logic          tx_ready_o,
  output logic          par_err_o
);
  localparam int SETTLE_RAW = (SETTLE_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;

  // synchronized request and direction; direction resets to "target sends"
  logic [1:0] raw_ctl, sync_ctl;
  logic       req_s, io_s;

  assign raw_ctl = {bus_io_i, bus_req_i};

  bir_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_ctl),
    .q     (sync_ctl)
  );
  assign req_s = sync_ctl[0];
  assign io_s  = sync_ctl[1];

  // settle timer
  logic tmr_start, tmr_run, tmr_done;

  bir_settle #(.CYC(SETTLE_CYC)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start),
    .run   (tmr_run),
    .done  (tmr_done)
  );

  // state
  hs_state_e     state_q, state_d;
  logic          ack_q, ack_d;
  logic [DW-1:0] dout_q;
  logic          dout_ld;
  logic [DW-1:0] rxd_q;
  logic          rxv_q, rxv_d;
  logic          rx_ld;
  logic          perr_q, perr_d;
  logic          rx_room;
  logic          rx_bad;

  assign rx_room = ~rxv_q | rx_ready_i;
  assign rx_bad  = ~(^{bus_d_i, bus_p_i});

  always_comb begin
    state_d    = state_q;
    ack_d      = ack_q;
    dout_ld    = 1'b0;
    rx_ld      = 1'b0;
    tmr_start  = 1'b0;
    tmr_run    = 1'b0;
    tx_ready_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_s) begin
          if (io_s) begin
            if (rx_room) begin
              rx_ld   = 1'b1;
              ack_d   = 1'b1;
              state_d = ST_ACK;
            end
          end else begin
            state_d = ST_TXWAIT;
          end
        end
      end
      ST_TXWAIT: begin
        tx_ready_o = 1'b1;
        if (tx_valid_i) begin
          dout_ld   = 1'b1;
          tmr_start = 1'b1;
          state_d   = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        tmr_run = 1'b1;
        if (tmr_done) begin
          ack_d   = 1'b1;
          state_d = ST_ACK;
        end
      end
      ST_ACK: begin
        if (!req_s) begin
          ack_d   = 1'b0;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    rxv_d  = rx_ld | (rxv_q & ~rx_ready_i);
    perr_d = perr_q | (rx_ld & rx_bad);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
      rxv_q   <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
      rxv_q   <= rxv_d;
      perr_q  <= perr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dout_q <= '0;
    else if (dout_ld) dout_q <= tx_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rxd_q <= '0;
    else if (rx_ld) rxd_q <= bus_d_i;
  end

  assign bus_d_o    = dout_q;
  assign bus_p_o    = ~(^dout_q);
  assign bus_oe_o   = ~io_s;
  assign bus_ack_o  = ack_q;
  assign rx_valid_o = rxv_q;
  assign rx_data_o  = rxd_q;
  assign par_err_o  = perr_q;

  // acknowledge only rises while the request is seen high
  p_ack_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(req_s));

  // acknowledge is held while the request stays high
  p_ack_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && req_s) |=> ack_q);

  // acknowledge only drops after the request was seen low
  p_ack_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_q) |-> !$past(req_s));

  // outgoing byte does not move while acknowledged
  p_data_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> $stable(dout_q));

  // no acknowledge while waiting for a host byte
  p_no_ack_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TXWAIT) |-> !ack_q);

  // held receive byte is kept until taken
  p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rxv_q && !rx_ready_i) |=> (rxv_q && $stable(rxd_q)));

  // parity error flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    perr_q |=> perr_q);
endmodule

// File: tb/tb_bus_init_responder.sv
module tb_bus_init_responder;
  localparam int CLK_NS    = 10;
  localparam int DW        = 8;
  localparam int PER_PS    = CLK_NS * 1000;
  localparam int SET_PS    = 55000;
  localparam int EXP_SET_R = (SET_PS + PER_PS - 1) / PER_PS;
  localparam int EXP_SET   = (EXP_SET_R < 1) ? 1 : EXP_SET_R;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_req, bus_io, bus_p_in;
  logic [DW-1:0] bus_d_in;
  logic [DW-1:0] bus_d_out;
  logic          bus_p_out, bus_oe, bus_ack;
  logic          rx_valid, rx_ready, tx_valid, tx_ready, par_err;
  logic [DW-1:0] rx_data, tx_data;

  int n_vec  = 0;
  int n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  bus_init_responder #(.DW(DW), .CLK_PERIOD_PS(PER_PS), .SETTLE_PS(SET_PS)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req_i  (bus_req),
    .bus_io_i   (bus_io),
    .bus_d_i    (bus_d_in),
    .bus_p_i    (bus_p_in),
    .bus_d_o    (bus_d_out),
    .bus_p_o    (bus_p_out),
    .bus_oe_o   (bus_oe),
    .bus_ack_o  (bus_ack),
    .rx_valid_o (rx_valid),
    .rx_data_o  (rx_data),
    .rx_ready_i (rx_ready),
    .tx_valid_i (tx_valid),
    .tx_data_i  (tx_data),
    .tx_ready_o (tx_ready),
    .par_err_o  (par_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic oddp(input logic [DW-1:0] b);
    int ones = 0;
    for (int i = 0; i < DW; i++) ones += int'(b[i]);
    return (ones % 2 == 0) ? 1'b1 : 1'b0;
  endfunction

  task automatic wait_ack(input logic lvl, input string tag);
    int t = 0;
    while (bus_ack !== lvl && t < 60) begin
      @(negedge clk);
      t++;
    end
    check(bus_ack === lvl, tag, int'(bus_ack), int'(lvl));
  endtask

  // drop request and check the release timing (R3)
  task automatic release_req;
    bus_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(bus_ack === 1'b1, "R3 ack held until request seen low", int'(bus_ack), 1);
    @(negedge clk);
    check(bus_ack === 1'b0, "R3 ack falls after request falls", int'(bus_ack), 0);
  endtask

  // target sends a byte; host consumes it afterwards if asked
  task automatic target_send(input logic [DW-1:0] b, input bit bad_par, input bit consume);
    bus_io   = 1'b1;
    bus_d_in = b;
    bus_p_in = oddp(b) ^ bad_par;
    repeat (3) @(negedge clk);
    check(bus_oe === 1'b0, "R9 bus released while target sends", int'(bus_oe), 0);
    bus_req = 1'b1;
    wait_ack(1'b1, "R2 ack on incoming byte");
    check(rx_valid === 1'b1 && rx_data === b, "R2 received byte", int'(rx_data), int'(b));
    repeat (3) @(negedge clk);
    check(bus_ack === 1'b1, "R3 ack held while request high", int'(bus_ack), 1);
    release_req();
    if (consume) begin
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
    end
  endtask

  // target asks for a byte; host offers it (optionally late)
  task automatic target_recv(input logic [DW-1:0] b, input int late);
    int t;
    int cnt;
    bus_io  = 1'b0;
    tx_data = b;
    tx_valid = (late == 0);
    repeat (3) @(negedge clk);
    check(bus_oe === 1'b1, "R9 bus driven while target receives", int'(bus_oe), 1);
    bus_req = 1'b1;
    if (late != 0) begin
      repeat (late) @(negedge clk);
      check(bus_ack === 1'b0, "R6 no ack without host byte", int'(bus_ack), 0);
      check(tx_ready === 1'b1, "R6 ready while stalled", int'(tx_ready), 1);
      tx_valid = 1'b1;
    end
    t = 0;
    while (!(tx_ready === 1'b1) && t < 60) begin
      @(negedge clk);
      t++;
    end
    check(tx_ready === 1'b1, "R6 byte taken", int'(tx_ready), 1);
    cnt = 0;
    t = 0;
    @(negedge clk);
    tx_valid = 1'b0;
    while (bus_ack !== 1'b1 && t < 60) begin
      cnt++;
      t++;
      @(negedge clk);
    end
    check(cnt == EXP_SET, "R5 settle cycles before ack", cnt, EXP_SET);
    check(bus_d_out === b, "R4 outgoing byte", int'(bus_d_out), int'(b));
    check(bus_p_out === oddp(b), "R4 outgoing parity", int'(bus_p_out), int'(oddp(b)));
    repeat (3) begin
      @(negedge clk);
      check(bus_d_out === b && bus_ack === 1'b1, "R4 data stable under ack",
            int'(bus_d_out), int'(b));
    end
    release_req();
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    bus_req  = 1'b0;
    bus_io   = 1'b1;
    bus_d_in = '0;
    bus_p_in = 1'b1;
    rx_ready = 1'b0;
    tx_valid = 1'b0;
    tx_data  = '0;
    repeat (3) @(negedge clk);
    check(bus_ack === 1'b0 && rx_valid === 1'b0 && tx_ready === 1'b0 &&
          par_err === 1'b0 && bus_oe === 1'b0, "R1 reset state",
          int'({bus_ack, rx_valid, tx_ready, par_err, bus_oe}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: all incoming byte values with good parity
    for (int v = 0; v < 256; v++) target_send(DW'(v), 1'b0, 1'b1);
    check(par_err === 1'b0, "R8 no error on good parity", int'(par_err), 0);

    // R4 R5: all outgoing byte values
    for (int v = 0; v < 256; v++) target_recv(DW'(v), 0);

    // R6: stall with no host byte
    target_recv(8'hA5, 20);
    target_recv(8'h00, 7);

    // R7: host still holds a byte
    target_send(8'h3C, 1'b0, 1'b0);
    bus_io   = 1'b1;
    bus_d_in = 8'hC3;
    bus_p_in = oddp(8'hC3);
    bus_req  = 1'b1;
    repeat (20) @(negedge clk);
    check(bus_ack === 1'b0, "R7 no ack while holding byte", int'(bus_ack), 0);
    check(rx_data === 8'h3C, "R7 held byte kept", int'(rx_data), 8'h3C);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    wait_ack(1'b1, "R7 ack after host takes byte");
    check(rx_data === 8'hC3 && rx_valid === 1'b1, "R7 new byte captured", int'(rx_data), 8'hC3);
    release_req();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;

    // R8: bad parity sets sticky flag
    check(par_err === 1'b0, "R8 clean before bad byte", int'(par_err), 0);
    target_send(8'h81, 1'b1, 1'b1);
    check(par_err === 1'b1, "R8 flag after bad parity", int'(par_err), 1);
    target_send(8'h7E, 1'b0, 1'b1);
    target_recv(8'h11, 0);
    check(par_err === 1'b1, "R8 flag stays set", int'(par_err), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule